// File: doc/BRIEF.md
# Frame-Class Rate Limit Accountant

This block sits beside a port's rate limiter and decides, frame by frame, whether a frame is subject to limiting and how many bytes it costs. A frame is presented for one cycle with its length and three class flags: broadcast, multicast and flooded unicast. A programmable selection mode picks which classes are limited. Each limited frame is charged its length plus optional fixed overheads for the inter-frame gap (12 bytes) and the preamble (8 bytes). One configuration drives both the ingress and the egress limiters, so the same overhead flags apply in both directions.

The charge is drawn from an internal token bucket. The bucket gains a programmed number of bytes on every tick pulse and never rises above a programmed depth. A limited frame passes only if the bucket holds at least its charge. A passing frame pays that charge out of the bucket. A refused frame and a frame outside the selected classes leave the bucket untouched. The verdict appears one cycle after the frame is presented. The bucket level is visible on a port, so the refill and limiting logic can follow the tokens that remain.

Top module: `frame_rate_acct`

## Requirements
- R1: With mode 0 (cfg_mode = 2'b00), every frame is limited, whatever its class flags.
- R2: With mode 1 (2'b01), a frame is limited when any of frm_bcast, frm_mcast or frm_flood is high; otherwise it is not.
- R3: With mode 2 (2'b10), a frame is limited when frm_bcast or frm_mcast is high; frm_flood alone does not select it.
- R4: With mode 3 (2'b11), a frame is limited only when frm_bcast is high.
- R5: A limited frame's res_charge equals frm_len, plus 12 when the gap flag is set, plus 8 when the preamble flag is set. A frame that is not limited reports res_charge = 0.
- R6: After reset, the mode is 0, both overhead flags are clear, the bucket level is 0, refill and depth hold the values of parameters RST_REFILL and RST_DEPTH, and res_valid is low.
- R7: In each cycle with tick high, the bucket level rises by the refill amount. After every update the level is clamped to the current depth.
- R8: A limited frame is allowed exactly when the bucket level at its presentation edge is at least its charge. An allowed frame lowers the level by its charge.
- R9: A limited frame that is refused leaves the bucket level unchanged. Any tick in the same cycle is still applied.
- R10: A frame that the mode does not select is always allowed and does not change the bucket level.
- R11: res_valid is high exactly in the cycle after a cycle with frm_valid high. When a frame and a tick arrive in the same cycle, the verdict uses the level from before the tick, and then both updates are applied.
- R12: A configuration write (cfg_we) takes effect at the following edge. If the new depth is lower than the current level, the level is clamped at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads all configuration fields |
| cfg_mode | input | 2 | Class selection mode |
| cfg_ifg_en | input | 1 | Charge 12 gap bytes per limited frame |
| cfg_pre_en | input | 1 | Charge 8 preamble bytes per limited frame |
| cfg_refill | input | BKT_W | Bytes added per tick |
| cfg_depth | input | BKT_W | Bucket ceiling |
| tick | input | 1 | Refill pulse |
| frm_valid | input | 1 | Frame presented this cycle |
| frm_len | input | LEN_W | Frame length in bytes |
| frm_bcast | input | 1 | Frame is broadcast |
| frm_mcast | input | 1 | Frame is multicast |
| frm_flood | input | 1 | Frame is flooded unicast |
| res_valid | output | 1 | Verdict valid |
| res_limited | output | 1 | Frame was selected for limiting |
| res_charge | output | LEN_W+1 | Bytes charged |
| res_allow | output | 1 | 1 = allow, 0 = drop |
| bkt_level | output | BKT_W | Current bucket level |

## Verification
The hardest cases to reach are the boundaries of the bucket. These are a charge that exactly equals the level, a frame that meets a tick on an empty bucket, and a depth lowered below a level already held. Reaching them needs the bucket driven to a known level first. The bench does this with counted ticks against a small refill. It then presents frames whose charge has been computed to land on, just above, or just below that level. A nested sweep over every mode, flag pair and class combination runs with a tick on alternate frames. A bench model of the level follows every step of the sweep.

// File: rtl/rl_acct_pkg.sv
package rl_acct_pkg;

   typedef enum logic [1:0] {
      LM_ALL        = 2'b00,
      LM_FL_MC_BC   = 2'b01,
      LM_MC_BC      = 2'b10,
      LM_BC         = 2'b11
   } lim_mode_e;

   typedef struct packed {
      lim_mode_e mode;
      logic      ifg_en;
      logic      pre_en;
   } shape_cfg_t;

   localparam int GAP_OVH_BYTES = 12;
   localparam int PRE_OVH_BYTES = 8;

endpackage

// File: rtl/rl_class_sel.sv
module rl_class_sel
   import rl_acct_pkg::*;
(
   input  lim_mode_e mode,
   input  logic      is_bc,
   input  logic      is_mc,
   input  logic      is_fl,
   output logic      sel
);

   always_comb begin
      unique case (mode)
         LM_ALL:      sel = 1'b1;
         LM_FL_MC_BC: sel = is_bc | is_mc | is_fl;
         LM_MC_BC:    sel = is_bc | is_mc;
         LM_BC:       sel = is_bc;
         default:     sel = 1'b1;
      endcase
   end

endmodule

// File: rtl/rl_charge_calc.sv
module rl_charge_calc #(
   parameter int LEN_W     = 14,
   parameter int GAP_BYTES = 12,
   parameter int PRE_BYTES = 8,
   localparam int CHG_W    = LEN_W + 1
) (
   input  logic [LEN_W-1:0] len,
   input  logic             gap_en,
   input  logic             pre_en,
   output logic [CHG_W-1:0] charge
);

   logic [CHG_W-1:0] gap_add;
   logic [CHG_W-1:0] pre_add;

   assign gap_add = gap_en ? CHG_W'(GAP_BYTES) : '0;
   assign pre_add = pre_en ? CHG_W'(PRE_BYTES) : '0;
   assign charge  = {1'b0, len} + gap_add + pre_add;

endmodule

// File: rtl/rl_token_bucket.sv
module rl_token_bucket #(
   parameter int BKT_W = 20,
   parameter int CHG_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [BKT_W-1:0] refill,
   input  logic [BKT_W-1:0] depth,
   input  logic             take_req,
   input  logic [CHG_W-1:0] take_amt,
   output logic             take_ok,
   output logic [BKT_W-1:0] level
);

   localparam int SUM_W = BKT_W + 1;

   logic [BKT_W-1:0] amt_ext;
   logic [BKT_W-1:0] after_take;
   logic [SUM_W-1:0] after_fill;
   logic [BKT_W-1:0] level_nx;

   assign amt_ext    = BKT_W'(take_amt);
   assign take_ok    = (level >= amt_ext);
   assign after_take = (take_req && take_ok) ? (level - amt_ext) : level;
   assign after_fill = {1'b0, after_take} + (tick ? {1'b0, refill} : '0);
   assign level_nx   = (after_fill > {1'b0, depth}) ? depth : after_fill[BKT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) level <= '0;
      else        level <= level_nx;
   end

endmodule

// File: rtl/frame_rate_acct.sv
module frame_rate_acct
   import rl_acct_pkg::*;
#(
   parameter int LEN_W      = 14,
   parameter int BKT_W      = 20,
   parameter int RST_REFILL = 64,
   parameter int RST_DEPTH  = 4096,
   localparam int CHG_W     = LEN_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_mode,
   input  logic             cfg_ifg_en,
   input  logic             cfg_pre_en,
   input  logic [BKT_W-1:0] cfg_refill,
   input  logic [BKT_W-1:0] cfg_depth,
   input  logic             tick,
   input  logic             frm_valid,
   input  logic [LEN_W-1:0] frm_len,
   input  logic             frm_bcast,
   input  logic             frm_mcast,
   input  logic             frm_flood,
   output logic             res_valid,
   output logic             res_limited,
   output logic [CHG_W-1:0] res_charge,
   output logic             res_allow,
   output logic [BKT_W-1:0] bkt_level
);

   if (LEN_W < 4) begin : g_bad_len
      $error("LEN_W too small");
   end
   if (BKT_W < CHG_W) begin : g_bad_bkt
      $error("BKT_W must hold a full charge");
   end
   if (RST_DEPTH >= (1 << BKT_W) || RST_REFILL >= (1 << BKT_W)) begin : g_bad_rst
      $error("reset refill or depth exceeds BKT_W");
   end

   shape_cfg_t       cfg_q;
   logic [BKT_W-1:0] refill_q;
   logic [BKT_W-1:0] depth_q;
   logic [1:0]       mode_cur;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q    <= '{mode: LM_ALL, ifg_en: 1'b0, pre_en: 1'b0};
         refill_q <= BKT_W'(RST_REFILL);
         depth_q  <= BKT_W'(RST_DEPTH);
      end else if (cfg_we) begin
         cfg_q    <= '{mode: lim_mode_e'(cfg_mode), ifg_en: cfg_ifg_en, pre_en: cfg_pre_en};
         refill_q <= cfg_refill;
         depth_q  <= cfg_depth;
      end
   end

   assign mode_cur = cfg_q.mode;

   logic             sel;
   logic [CHG_W-1:0] charge;
   logic             take_ok;

   rl_class_sel u_sel (
      .mode  (cfg_q.mode),
      .is_bc (frm_bcast),
      .is_mc (frm_mcast),
      .is_fl (frm_flood),
      .sel   (sel)
   );

   rl_charge_calc #(
      .LEN_W     (LEN_W),
      .GAP_BYTES (GAP_OVH_BYTES),
      .PRE_BYTES (PRE_OVH_BYTES)
   ) u_chg (
      .len    (frm_len),
      .gap_en (cfg_q.ifg_en),
      .pre_en (cfg_q.pre_en),
      .charge (charge)
   );

   rl_token_bucket #(
      .BKT_W (BKT_W),
      .CHG_W (CHG_W)
   ) u_bkt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .refill   (refill_q),
      .depth    (depth_q),
      .take_req (frm_valid && sel),
      .take_amt (charge),
      .take_ok  (take_ok),
      .level    (bkt_level)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_limited <= 1'b0;
         res_charge  <= '0;
         res_allow   <= 1'b0;
      end else begin
         res_valid   <= frm_valid;
         res_limited <= frm_valid && sel;
         res_charge  <= (frm_valid && sel) ? charge : '0;
         res_allow   <= frm_valid && (!sel || take_ok);
      end
   end

endmodule

// File: rtl/frame_rate_acct_chk.sv
module frame_rate_acct_chk #(
   parameter int BKT_W = 20,
   parameter int CHG_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             frm_valid,
   input logic             frm_bcast,
   input logic [1:0]       mode_cur,
   input logic [BKT_W-1:0] depth_q,
   input logic             res_valid,
   input logic             res_limited,
   input logic [CHG_W-1:0] res_charge,
   input logic             res_allow,
   input logic [BKT_W-1:0] bkt_level
);

   // R4
   bc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && mode_cur == 2'b11 && !frm_bcast) |=> !res_limited);

   // R7
   depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> bkt_level <= $past(depth_q));

   // R8
   pay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_limited && res_allow && !$past(tick) && $past(depth_q) == $past(depth_q, 2))
      |-> bkt_level == $past(bkt_level) - BKT_W'(res_charge));

   // R9
   drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_allow && !$past(tick) && $past(depth_q) == $past(depth_q, 2))
      |-> bkt_level == $past(bkt_level));

   // R10
   unsel_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_limited) |-> (res_allow && res_charge == '0));

   // R11
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> res_valid);

   // R11
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> !res_valid);

endmodule

bind frame_rate_acct frame_rate_acct_chk #(
   .BKT_W (BKT_W),
   .CHG_W (CHG_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .frm_valid   (frm_valid),
   .frm_bcast   (frm_bcast),
   .mode_cur    (mode_cur),
   .depth_q     (depth_q),
   .res_valid   (res_valid),
   .res_limited (res_limited),
   .res_charge  (res_charge),
   .res_allow   (res_allow),
   .bkt_level   (bkt_level)
);

// File: tb/frame_rate_acct_bench.sv
module frame_rate_acct_bench;

   localparam int CLK_PERIOD = 10;
   localparam int LEN_W      = 8;
   localparam int BKT_W      = 10;
   localparam int CHG_W      = LEN_W + 1;
   localparam int RST_REFILL = 16;
   localparam int RST_DEPTH  = 600;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [1:0]       cfg_mode = '0;
   logic             cfg_ifg_en = 1'b0;
   logic             cfg_pre_en = 1'b0;
   logic [BKT_W-1:0] cfg_refill = '0;
   logic [BKT_W-1:0] cfg_depth = '0;
   logic             tick = 1'b0;
   logic             frm_valid = 1'b0;
   logic [LEN_W-1:0] frm_len = '0;
   logic             frm_bcast = 1'b0;
   logic             frm_mcast = 1'b0;
   logic             frm_flood = 1'b0;
   logic             res_valid;
   logic             res_limited;
   logic [CHG_W-1:0] res_charge;
   logic             res_allow;
   logic [BKT_W-1:0] bkt_level;

   frame_rate_acct #(
      .LEN_W      (LEN_W),
      .BKT_W      (BKT_W),
      .RST_REFILL (RST_REFILL),
      .RST_DEPTH  (RST_DEPTH)
   ) u_frame_rate_acct (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_mode    (cfg_mode),
      .cfg_ifg_en  (cfg_ifg_en),
      .cfg_pre_en  (cfg_pre_en),
      .cfg_refill  (cfg_refill),
      .cfg_depth   (cfg_depth),
      .tick        (tick),
      .frm_valid   (frm_valid),
      .frm_len     (frm_len),
      .frm_bcast   (frm_bcast),
      .frm_mcast   (frm_mcast),
      .frm_flood   (frm_flood),
      .res_valid   (res_valid),
      .res_limited (res_limited),
      .res_charge  (res_charge),
      .res_allow   (res_allow),
      .bkt_level   (bkt_level)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   int m_mode, m_ifg, m_pre, m_refill, m_depth, m_level;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit exp_sel(input int md, input bit b, input bit m, input bit f);
      case (md)
         0: return 1'b1;
         1: return b | m | f;
         2: return b | m;
         default: return b;
      endcase
   endfunction

   function automatic string mode_req(input int md);
      case (md)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic step(input bit f, input int len, input bit b, input bit m,
                       input bit fl, input bit tk);
      bit lim, allow;
      int chg, nl;
      lim   = f && exp_sel(m_mode, b, m, fl);
      chg   = lim ? len + (m_ifg ? 12 : 0) + (m_pre ? 8 : 0) : 0;
      allow = !lim || (m_level >= chg);
      frm_valid = f; frm_len = LEN_W'(len);
      frm_bcast = b; frm_mcast = m; frm_flood = fl; tick = tk;
      @(posedge clk);
      @(negedge clk);
      frm_valid = 1'b0; tick = 1'b0;
      chk(res_valid == f, "R11", int'(res_valid), int'(f));
      if (f) begin
         chk(res_limited == lim, mode_req(m_mode), int'(res_limited), int'(lim));
         chk(int'(res_charge) == chg, "R5", int'(res_charge), chg);
         chk(res_allow == allow, lim ? "R8" : "R10", int'(res_allow), int'(allow));
      end
      nl = m_level - ((lim && allow) ? chg : 0) + (tk ? m_refill : 0);
      if (nl > m_depth) nl = m_depth;
      m_level = nl;
      chk(int'(bkt_level) == m_level, (lim && !allow) ? "R9" : "R7", int'(bkt_level), m_level);
   endtask

   task automatic cfg(input int md, input bit ig, input bit pr, input int rf, input int dp);
      cfg_we = 1'b1; cfg_mode = 2'(md); cfg_ifg_en = ig; cfg_pre_en = pr;
      cfg_refill = BKT_W'(rf); cfg_depth = BKT_W'(dp);
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      m_mode = md; m_ifg = ig; m_pre = pr; m_refill = rf; m_depth = dp;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_mode = 0; m_ifg = 0; m_pre = 0;
      m_refill = RST_REFILL; m_depth = RST_DEPTH; m_level = 0;
      // R6: reset state
      chk(res_valid == 1'b0, "R6", int'(res_valid), 0);
      chk(bkt_level == '0, "R6", int'(bkt_level), 0);
      // R6: reset mode 0 with no overhead; empty bucket refuses
      step(1'b1, 64, 1'b0, 1'b0, 1'b0, 1'b0);
      // R6: reset refill applies
      step(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk(int'(bkt_level) == RST_REFILL, "R6", int'(bkt_level), RST_REFILL);

      // R8 boundary: charge equal to level passes, one more byte fails
      cfg(0, 1'b0, 1'b0, 100, 900);
      step(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
      step(1'b1, 116, 1'b1, 1'b0, 1'b0, 1'b0);
      chk(bkt_level == '0, "R8", int'(bkt_level), 0);
      step(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
      step(1'b1, 101, 1'b0, 1'b1, 1'b0, 1'b0);
      chk(res_allow == 1'b0, "R9", int'(res_allow), 0);

      // R11: frame and tick together on a low bucket use the pre-tick level
      cfg(0, 1'b1, 1'b1, 200, 900);
      step(1'b1, 90, 1'b0, 1'b0, 1'b0, 1'b1);
      chk(int'(bkt_level) == 300, "R11", int'(bkt_level), 300);

      // R7: saturation at depth
      for (int i = 0; i < 6; i++) step(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk(int'(bkt_level) == 900, "R7", int'(bkt_level), 900);

      // R12: lowering depth clamps the level on the next edge
      cfg(0, 1'b0, 1'b0, 200, 250);
      chk(int'(bkt_level) == 900, "R12", int'(bkt_level), 900);
      step(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk(int'(bkt_level) == 250, "R12", int'(bkt_level), 250);

      // R1-to-R5 sweep over every mode, flag pair and class combination
      for (int md = 0; md < 4; md++) begin
         for (int fg = 0; fg < 4; fg++) begin
            cfg(md, fg[0], fg[1], 60, 400);
            for (int cl = 0; cl < 8; cl++) begin
               for (int k = 0; k < 2; k++) begin
                  step(1'b1, 1 + ((cl * 29 + k * 97 + md * 13 + fg * 7) % 250),
                       cl[0], cl[1], cl[2], k == 0);
               end
            end
            step(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule